// File: doc/BRIEF.md
# Queued Conversion Command Sequencer

This block walks a queue of conversion command words and issues one conversion to a converter for each word. The converter is modelled as a fixed-latency timer: a start pulse is followed by an end-of-conversion event a set number of queue-clock cycles later. Each command word carries two control bits. The pause bit makes the sequencer wait for a fresh trigger before it moves on. The end-of-queue bit stops the scan after that word.

A scan can begin in one of three ways. In trigger mode, a trigger pulse starts the queue at word 0 and also releases the queue from a pause point. In gated single-scan mode, the scan runs while an external gate is high and the single-scan enable is armed. In gated continuous mode, the scan runs while the gate is high and wraps around at the end of the queue.

The block has two pointers. The working pointer names the word being converted. A second pointer trails it and records the index of the most recent result. Result write strobes carry the result slot index. The completion flag and the pause flag stay set until software writes 1 to clear them.

Top module: `ccw_seq_top`

## Requirements
- R1: A conversion ends 14 queue-clock cycles after it starts. With a trigger held high for one cycle in trigger mode, `res_we` is high for one cycle in the 14th cycle after the edge that sampled the trigger.
- R2: In trigger mode (`mode`=0), after the conversion of a word whose pause bit is 1, the sequencer does the following. It holds `cwp` on that word, sets `pf` and starts nothing further. The next trigger moves `cwp` to the following word and starts its conversion.
- R3: `cwpq` takes the value of `cwp` only at a result write. During a conversion it still holds the previous index. Whenever the queue is idle or paused, it equals `cwp`.
- R4: Every scan starts at word 0 and converts words in rising index order. Each result is written with `res_idx` equal to the index of the word just converted.
- R5: In the gated modes, if the gate goes low during a conversion, that conversion completes and is written, and then the queue goes idle. If that word was not the end of the queue, `pf` sets.
- R6: In gated single-scan mode (`mode`=1), when the gate opens again after a closure, the scan restarts at word 0.
- R7: When a gated single-scan reaches the end of the queue, `cf` sets and `sse` clears, so no new scan starts while the gate stays high.
- R8: In the gated modes, pause bits have no effect.
- R9: A word whose end-of-queue bit is 1, or the last array entry, ends the scan and sets `cf`. In trigger mode, the end of the queue takes precedence over a pause bit on the same word. In gated continuous mode (`mode`=2), the pointer wraps to word 0 while the gate stays high.
- R10: `flag_clr` bit 0 clears `cf` and bit 1 clears `pf`, in the cycle after the write. A set event in the same cycle wins over the clear.
- R11: While `rst` is high, both pointers are 0, `cf`, `pf`, `sse` and `res_we` are 0, and the queue is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Queue clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 trigger, 1 gated single-scan, 2 gated continuous, 3 no scan starts |
| trig | input | 1 | Trigger pulse, used in trigger mode |
| gate | input | 1 | External gate level, used in the gated modes |
| sse_set | input | 1 | Pulse that arms the single-scan enable |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 `cf`, bit 1 `pf` |
| ccw_pause | input | DEPTH | Pause bit of each command word |
| ccw_eoq | input | DEPTH | End-of-queue bit of each command word |
| cwp | output | IDXW | Working command word pointer |
| cwpq | output | IDXW | Lagging pointer, last written result index |
| res_we | output | 1 | Result write strobe |
| res_idx | output | IDXW | Result slot index for the write |
| cf | output | 1 | Queue completion flag |
| pf | output | 1 | Pause or early-closure flag |
| sse | output | 1 | Single-scan enable state |

## Verification
The assertions take for granted that `mode` and the command word bits are changed only while the queue is idle. They also assume that `trig`, `sse_set` and `flag_clr` are single-cycle pulses. The bench holds to these assumptions: it drives a new mode and new masks only right after a reset. It pulses every strobe for exactly one clock, and it moves the gate only at chosen points inside or between conversions.

// File: rtl/ccw_seq_pkg.sv
package ccw_seq_pkg;

    typedef enum logic [1:0] {
        MODE_TRIG    = 2'd0,
        MODE_GSINGLE = 2'd1,
        MODE_GCONT   = 2'd2,
        MODE_OFF     = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONV   = 2'd1,
        ST_PAUSED = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic set_done;
        logic set_pause;
        logic clr_sse;
    } stat_evt_t;

    function automatic logic is_gated(scan_mode_e m);
        return (m == MODE_GSINGLE) || (m == MODE_GCONT);
    endfunction

endpackage

// File: rtl/ccw_conv_timer.sv
module ccw_conv_timer #(
    parameter int CONV_CYCLES = 14,
    localparam int CW = $clog2(CONV_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic eoc
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CONV_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign eoc = (cnt == CW'(1));

    // R1: a new conversion is only requested when the converter is free
    a_r1_start_when_free: assert property (@(posedge clk) disable iff (rst)
        start |-> (cnt == '0 || eoc));

    // R1: end of conversion is a single-cycle event
    a_r1_eoc_single: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

endmodule

// File: rtl/ccw_seq_ctrl.sv
module ccw_seq_ctrl
    import ccw_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  scan_mode_e       mode,
    input  logic             trig,
    input  logic             gate,
    input  logic             sse,
    input  logic [DEPTH-1:0] ccw_pause,
    input  logic [DEPTH-1:0] ccw_eoq,
    input  logic             eoc,
    output logic             start,
    output logic [IDXW-1:0]  cwp,
    output logic [IDXW-1:0]  cwpq,
    output logic             res_we,
    output logic [IDXW-1:0]  res_idx,
    output stat_evt_t        evt
);
    seq_state_e      st, st_n;
    logic [IDXW-1:0] cwp_n;
    logic            gate_lost;
    logic            at_last;
    logic            stop_gate;

    assign at_last   = ccw_eoq[cwp] || (cwp == IDXW'(DEPTH - 1));
    assign stop_gate = gate_lost || !gate;
    assign res_we    = eoc && (st == ST_CONV);
    assign res_idx   = cwp;

    always_comb begin
        st_n  = st;
        cwp_n = cwp;
        start = 1'b0;
        evt   = '0;
        unique case (st)
            ST_IDLE: begin
                if ((mode == MODE_TRIG && trig) ||
                    (mode == MODE_GSINGLE && gate && sse) ||
                    (mode == MODE_GCONT && gate)) begin
                    cwp_n = '0;
                    start = 1'b1;
                    st_n  = ST_CONV;
                end
            end
            ST_CONV: begin
                if (eoc) begin
                    if (is_gated(mode)) begin
                        if (at_last) begin
                            evt.set_done = 1'b1;
                            if (mode == MODE_GSINGLE) begin
                                evt.clr_sse = 1'b1;
                                st_n = ST_IDLE;
                            end else if (!stop_gate) begin
                                cwp_n = '0;
                                start = 1'b1;
                            end else begin
                                st_n = ST_IDLE;
                            end
                        end else if (stop_gate) begin
                            evt.set_pause = 1'b1;
                            st_n = ST_IDLE;
                        end else begin
                            cwp_n = cwp + IDXW'(1);
                            start = 1'b1;
                        end
                    end else begin
                        if (at_last) begin
                            evt.set_done = 1'b1;
                            st_n = ST_IDLE;
                        end else if (ccw_pause[cwp]) begin
                            evt.set_pause = 1'b1;
                            st_n = ST_PAUSED;
                        end else begin
                            cwp_n = cwp + IDXW'(1);
                            start = 1'b1;
                        end
                    end
                end
            end
            ST_PAUSED: begin
                if (mode == MODE_TRIG && trig) begin
                    cwp_n = cwp + IDXW'(1);
                    start = 1'b1;
                    st_n  = ST_CONV;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cwp       <= '0;
            cwpq      <= '0;
            gate_lost <= 1'b0;
        end else begin
            st  <= st_n;
            cwp <= cwp_n;
            if (res_we)
                cwpq <= cwp;
            if (start)
                gate_lost <= 1'b0;
            else if (st == ST_CONV && !gate)
                gate_lost <= 1'b1;
        end
    end

    // R2: a paused queue holds its pointer until a trigger arrives
    a_r2_hold_paused: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAUSED && !trig) |=> $stable(cwp));

    // R3: lagging pointer matches the working pointer whenever inactive
    a_r3_idle_match: assert property (@(posedge clk) disable iff (rst)
        (st != ST_CONV) |-> (cwpq == cwp));

    // R3: a result write is mirrored into the lagging pointer
    a_r3_write_to_lag: assert property (@(posedge clk) disable iff (rst)
        res_we |=> (cwpq == $past(res_idx)));

    // R5: no gated conversion begins with the gate low
    a_r5_gate_open_start: assert property (@(posedge clk) disable iff (rst)
        (start && is_gated(mode)) |-> gate);

endmodule

// File: rtl/ccw_seq_status.sv
module ccw_seq_status
    import ccw_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stat_evt_t  evt,
    input  logic [1:0] flag_clr,
    input  logic       sse_set,
    output logic       cf,
    output logic       pf,
    output logic       sse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cf  <= 1'b0;
            pf  <= 1'b0;
            sse <= 1'b0;
        end else begin
            if (evt.set_done)
                cf <= 1'b1;
            else if (flag_clr[0])
                cf <= 1'b0;
            if (evt.set_pause)
                pf <= 1'b1;
            else if (flag_clr[1])
                pf <= 1'b0;
            if (evt.clr_sse)
                sse <= 1'b0;
            else if (sse_set)
                sse <= 1'b1;
        end
    end

    // R10: a completion event wins over a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt.set_done |=> cf);

    // R10: a clear with no set event drops the pause flag
    a_r10_clear_pf: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[1] && !evt.set_pause) |=> !pf);

    // R7: finishing a single scan disarms the enable
    a_r7_sse_drop: assert property (@(posedge clk) disable iff (rst)
        evt.clr_sse |=> !sse);

endmodule

// File: rtl/ccw_seq_top.sv
module ccw_seq_top
    import ccw_seq_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int CONV_CYCLES = 14,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             trig,
    input  logic             gate,
    input  logic             sse_set,
    input  logic [1:0]       flag_clr,
    input  logic [DEPTH-1:0] ccw_pause,
    input  logic [DEPTH-1:0] ccw_eoq,
    output logic [IDXW-1:0]  cwp,
    output logic [IDXW-1:0]  cwpq,
    output logic             res_we,
    output logic [IDXW-1:0]  res_idx,
    output logic             cf,
    output logic             pf,
    output logic             sse
);
    logic      start;
    logic      eoc;
    stat_evt_t evt;

    ccw_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .eoc   (eoc)
    );

    ccw_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (scan_mode_e'(mode)),
        .trig      (trig),
        .gate      (gate),
        .sse       (sse),
        .ccw_pause (ccw_pause),
        .ccw_eoq   (ccw_eoq),
        .eoc       (eoc),
        .start     (start),
        .cwp       (cwp),
        .cwpq      (cwpq),
        .res_we    (res_we),
        .res_idx   (res_idx),
        .evt       (evt)
    );

    ccw_seq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .flag_clr (flag_clr),
        .sse_set  (sse_set),
        .cf       (cf),
        .pf       (pf),
        .sse      (sse)
    );

endmodule

// File: tb/tb_ccw_seq_top.sv
module tb_ccw_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 8 * 14 + 20;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       trig, gate, sse_set;
    logic [1:0] flag_clr;
    logic [7:0] ccw_pause, ccw_eoq;
    logic [2:0] cwp, cwpq, res_idx;
    logic       res_we, cf, pf, sse;

    int total = 0;
    int bad   = 0;
    int wr_cnt;
    int wlog [64];

    ccw_seq_top dut (
        .clk(clk), .rst(rst), .mode(mode), .trig(trig), .gate(gate),
        .sse_set(sse_set), .flag_clr(flag_clr), .ccw_pause(ccw_pause),
        .ccw_eoq(ccw_eoq), .cwp(cwp), .cwpq(cwpq), .res_we(res_we),
        .res_idx(res_idx), .cf(cf), .pf(pf), .sse(sse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] eoq;
        logic [7:0] pause;
        logic [7:0] writes;
        logic [2:0] last;
        logic       cf;
        logic       pf;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'h08, 8'h00, 8'd4, 3'd3, 1'b1, 1'b0},
        '{2'd0, 8'h00, 8'h00, 8'd8, 3'd7, 1'b1, 1'b0},
        '{2'd0, 8'h80, 8'h04, 8'd3, 3'd2, 1'b0, 1'b1},
        '{2'd0, 8'h01, 8'h00, 8'd1, 3'd0, 1'b1, 1'b0},
        '{2'd1, 8'h20, 8'h02, 8'd6, 3'd5, 1'b1, 1'b0},
        '{2'd0, 8'h10, 8'h10, 8'd5, 3'd4, 1'b1, 1'b0}
    };

    function automatic string vreq(int i);
        case (i)
            2: return "R2";
            4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (res_we) begin
            if (wr_cnt < 64) wlog[wr_cnt] = int'(res_idx);
            wr_cnt++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; trig = 1'b0; gate = 1'b0; sse_set = 1'b0;
        flag_clr = 2'b00; mode = 2'd0; ccw_pause = '0; ccw_eoq = '0;
        repeat (3) step();
        rst = 1'b0;
        wr_cnt = 0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1; step(); trig = 1'b0;
    endtask

    task automatic wait_writes(int n);
        int guard = 0;
        while (wr_cnt < n && guard < 400) begin step(); guard++; end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int snap;

        // R11 reset state
        rst = 1'b1; trig = 1'b0; gate = 1'b0; sse_set = 1'b0;
        flag_clr = 2'b00; mode = 2'd0; ccw_pause = '0; ccw_eoq = '0;
        wr_cnt = 0;
        repeat (3) step();
        chk("R11", "cwp", int'(cwp), 0);
        chk("R11", "cwpq", int'(cwpq), 0);
        chk("R11", "flags", int'({cf, pf, sse, res_we}), 0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            do_reset();
            mode = VECS[i].mode; ccw_eoq = VECS[i].eoq; ccw_pause = VECS[i].pause;
            if (VECS[i].mode == 2'd1) begin
                sse_set = 1'b1; step(); sse_set = 1'b0; gate = 1'b1;
            end else begin
                pulse_trig();
            end
            repeat (RUN_LEN) step();
            gate = 1'b0;
            chk(vreq(i), $sformatf("vec%0d writes", i), wr_cnt, int'(VECS[i].writes));
            for (int k = 0; k < wr_cnt && k < 8; k++)
                chk("R4", $sformatf("vec%0d idx%0d", i, k), wlog[k], k);
            chk(vreq(i), $sformatf("vec%0d cwp", i), int'(cwp), int'(VECS[i].last));
            chk("R3", $sformatf("vec%0d cwpq", i), int'(cwpq), int'(VECS[i].last));
            chk(vreq(i), $sformatf("vec%0d cf", i), int'(cf), int'(VECS[i].cf));
            chk(vreq(i), $sformatf("vec%0d pf", i), int'(pf), int'(VECS[i].pf));
            if (VECS[i].mode == 2'd1)
                chk("R7", $sformatf("vec%0d sse", i), int'(sse), 0);
        end

        // R1 latency in trigger mode
        do_reset();
        ccw_eoq = 8'h01;
        pulse_trig();
        lat = 1;
        while (!res_we && lat < 100) begin step(); lat++; end
        chk("R1", "latency", lat, 14);
        step();
        chk("R1", "strobe one cycle", int'(res_we), 0);

        // R2 / R3 pause and lag
        do_reset();
        ccw_pause = 8'h02; ccw_eoq = 8'h08;
        pulse_trig();
        wait_writes(1);
        step();
        chk("R3", "lag cwp", int'(cwp), 1);
        chk("R3", "lag cwpq", int'(cwpq), 0);
        pulse_trig();                      // ignored mid-conversion
        repeat (40) step();
        chk("R2", "held writes", wr_cnt, 2);
        chk("R2", "held cwp", int'(cwp), 1);
        chk("R2", "pf", int'(pf), 1);
        chk("R3", "paused cwpq", int'(cwpq), 1);
        pulse_trig();
        chk("R2", "resume cwp", int'(cwp), 2);
        lat = 1;
        while (!res_we && lat < 100) begin step(); lat++; end
        chk("R2", "resume latency", lat, 14);
        repeat (40) step();
        chk("R2", "final writes", wr_cnt, 4);
        chk("R4", "resume idx", wlog[2], 2);
        chk("R9", "done cf", int'(cf), 1);

        // R10 clear cf keeps pf
        flag_clr = 2'b01; step(); flag_clr = 2'b00;
        chk("R10", "cf cleared", int'(cf), 0);
        chk("R10", "pf kept", int'(pf), 1);

        // R5 graceful gate closure in single scan
        do_reset();
        mode = 2'd1;
        sse_set = 1'b1; step(); sse_set = 1'b0;
        gate = 1'b1;
        wait_writes(1);
        repeat (5) step();
        gate = 1'b0;
        repeat (40) step();
        chk("R5", "writes after close", wr_cnt, 2);
        chk("R5", "last idx", wlog[1], 1);
        chk("R5", "pf", int'(pf), 1);
        chk("R5", "cf", int'(cf), 0);
        chk("R5", "sse kept", int'(sse), 1);
        flag_clr = 2'b10; step(); flag_clr = 2'b00;
        chk("R10", "pf cleared", int'(pf), 0);

        // R6 reopen restarts at word 0, R7 completion
        wr_cnt = 0;
        gate = 1'b1; step();
        lat = 1;
        while (!res_we && lat < 100) begin step(); lat++; end
        chk("R6", "restart latency", lat, 14);
        chk("R6", "restart idx", wlog[0], 0);
        repeat (RUN_LEN) step();
        chk("R7", "full scan writes", wr_cnt, 8);
        chk("R7", "cf", int'(cf), 1);
        chk("R7", "sse cleared", int'(sse), 0);
        chk("R7", "pf stays clear", int'(pf), 0);
        gate = 1'b0;

        // R9 continuous wrap
        do_reset();
        mode = 2'd2; ccw_eoq = 8'h04; ccw_pause = 8'h01;
        gate = 1'b1;
        repeat (14 * 7 + 5) step();
        chk("R9", "wrap writes", wr_cnt, 7);
        chk("R9", "idx2", wlog[2], 2);
        chk("R9", "wrap idx3", wlog[3], 0);
        chk("R9", "wrap idx6", wlog[6], 0);
        chk("R9", "cf", int'(cf), 1);
        gate = 1'b0;
        repeat (40) step();
        snap = wr_cnt;
        repeat (40) step();
        chk("R5", "stopped", wr_cnt, snap);
        chk("R3", "idle match", int'(cwpq), int'(cwp));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule